// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block sits beside the register file of a small microcontroller-class core and carries out the two sequences that move the core into and out of an exception handler. A request names an external interrupt index (signed, so system exceptions carry negative indices) and a priority byte. The block checks the request against three mask inputs. If the request is taken, the block saves an eight-word context frame on the stack that is active at that moment. It then fetches the handler address from the vector table and loads the status, program-counter and link registers.

A return request reverses the sequence. It clears the exception number and picks the stack from bit 2 of the supplied return value. It then pops the frame back into the registers, restoring only the flag fields of the saved status word. A supervisor-call trap does not start a sequence. It only raises a pending pulse for the interrupt controller.

All register traffic goes through a combinational read port and a single write port, using 4-bit register codes. All memory traffic goes through one word-wide request/acknowledge port. The block handles one sequence at a time and reports this with a busy flag.

Top module: `exc_seq`

## Requirements
- R1: When `pri_mask_i` is 1, a request whose signed index is greater than -13 (the hard-fault index) is not taken: busy stays 0 and no memory or register access occurs.
- R2: When `flt_mask_i` is 1, every request except index -14 (NMI) is not taken.
- R3: Only bits [7:4] of `base_pri_i` count. When the value `{base_pri_i[7:4],4'h0}` is nonzero and less than or equal to `req_prio_i`, the request is not taken.
- R4: When a request is taken at a clock edge, `busy_o` is 1 from that edge until the sequence ends. Requests presented while busy are ignored. `busy_o` is 0 after reset.
- R5: Register codes are R0..R3 = 0..3, R12 = 4, LR = 5, PC = 6, xPSR = 7, main SP = 8, process SP = 9, CONTROL = 10. On entry, the words xPSR, PC, LR, R12, R3, R2, R1, R0 go to stack addresses SP-4, SP-8, ... SP-32 in that order. The chosen SP register ends at SP-32.
- R6: The exception number is index + 16. It is written to xPSR[8:0], with the other xPSR bits kept. PC is loaded with the word at byte address (exception number × 4).
- R7: The process stack is in use only when xPSR[8:0] ≤ 1 and CONTROL[1] is 1. LR is loaded with 0xFFFFFFFD in that case and with 0xFFFFFFF9 otherwise.
- R8: On return, xPSR[8:0] is cleared. CONTROL[1] is set to bit 2 of `exc_ret_val_i`, and the frame is popped from the process stack if that bit is 1 and from the main stack otherwise.
- R9: On return, the words are read upward from the selected SP into R0, R1, R2, R3, R12, LR, PC, xPSR in that order. The SP register ends 32 higher.
- R10: The popped xPSR word updates only bits [31:27] and [19:16]. All other xPSR bits, including the exception number, keep their values.
- R11: A cycle with `svc_trap_i` high gives a one-cycle `svc_pend_o` pulse on the next cycle, and starts no sequence.
- R12: A memory request holds its address, direction and data until acknowledged. An entry makes exactly 9 accesses and a return exactly 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Exception request strobe |
| req_irq_i | input | EXCW | Signed interrupt index |
| req_prio_i | input | 8 | Priority of the request |
| exc_ret_i | input | 1 | Exception-return strobe (wins over a request in the same cycle) |
| exc_ret_val_i | input | 32 | Magic return value |
| svc_trap_i | input | 1 | Supervisor-call trap |
| pri_mask_i | input | 1 | Primary mask bit |
| flt_mask_i | input | 1 | Fault mask bit |
| base_pri_i | input | 8 | Base-priority register |
| xpsr_i | input | 32 | Current status register |
| control_i | input | 32 | Current control register |
| reg_raddr_o | output | 4 | Register read code |
| reg_rdata_i | input | 32 | Register read data (same cycle) |
| reg_we_o | output | 1 | Register write enable |
| reg_waddr_o | output | 4 | Register write code |
| reg_wdata_o | output | 32 | Register write data |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write (1) or read (0) |
| mem_addr_o | output | 32 | Byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid with acknowledge |
| mem_ack_i | input | 1 | Access acknowledge |
| busy_o | output | 1 | Sequence in progress |
| svc_pend_o | output | 1 | SVCall pending pulse |

## Verification
The busy flag and the pending-call pulse are due one clock after the input that causes them. The bench drives that input on a falling edge and samples on the next falling edge. Entry and return last a variable number of cycles, because the memory model acknowledges after a random delay. So the bench waits for busy to fall, and only then compares registers, stack words and access counts with values computed from the requirements. For a rejected request it waits four more cycles and confirms that nothing moved.

// File: rtl/exc_seq.sv
module exc_seq #(
  parameter int EXCW = 9
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_valid_i,
  input  logic signed [EXCW-1:0] req_irq_i,
  input  logic [7:0]             req_prio_i,
  input  logic                   exc_ret_i,
  input  logic [31:0]            exc_ret_val_i,
  input  logic                   svc_trap_i,
  input  logic                   pri_mask_i,
  input  logic                   flt_mask_i,
  input  logic [7:0]             base_pri_i,
  input  logic [31:0]            xpsr_i,
  input  logic [31:0]            control_i,
  output logic [3:0]             reg_raddr_o,
  input  logic [31:0]            reg_rdata_i,
  output logic                   reg_we_o,
  output logic [3:0]             reg_waddr_o,
  output logic [31:0]            reg_wdata_o,
  output logic                   mem_req_o,
  output logic                   mem_we_o,
  output logic [31:0]            mem_addr_o,
  output logic [31:0]            mem_wdata_o,
  input  logic [31:0]            mem_rdata_i,
  input  logic                   mem_ack_i,
  output logic                   busy_o,
  output logic                   svc_pend_o
);

  localparam logic [3:0] RG_LR   = 4'd5;
  localparam logic [3:0] RG_PC   = 4'd6;
  localparam logic [3:0] RG_XPSR = 4'd7;
  localparam logic [3:0] RG_MSP  = 4'd8;
  localparam logic [3:0] RG_PSP  = 4'd9;
  localparam logic [3:0] RG_CTRL = 4'd10;
  localparam logic signed [EXCW-1:0] NMI_IRQ = -14;
  localparam logic signed [EXCW-1:0] HF_IRQ  = -13;
  localparam logic [EXCW-1:0] EXC_OFS = EXCW'(16);
  localparam logic [31:0] RET_PROC = 32'hFFFF_FFFD;
  localparam logic [31:0] RET_MAIN = 32'hFFFF_FFF9;

  typedef enum logic [3:0] {
    S_IDLE, S_E_SP, S_E_RD, S_E_WR, S_E_SPW, S_E_VEC, S_E_XPSR, S_E_PC, S_E_LR,
    S_R_XPSR, S_R_CTRL, S_R_SP, S_R_RD, S_R_WR, S_R_SPW
  } st_t;

  st_t             st;
  logic [2:0]      cnt;
  logic [31:0]     sp;
  logic [31:0]     wbuf;
  logic [EXCW-1:0] exc_q;
  logic            proc_q;
  logic            ret_q;

  logic pm_ok, fm_ok, bp_ok, take, on_proc;
  logic [EXCW-1:0] exc_n;
  logic unused_bits;

  assign pm_ok   = !(pri_mask_i && (req_irq_i > HF_IRQ));
  assign fm_ok   = !(flt_mask_i && (req_irq_i != NMI_IRQ));
  assign bp_ok   = !((base_pri_i[7:4] != 4'd0) && ({base_pri_i[7:4], 4'h0} <= req_prio_i));
  assign take    = req_valid_i && pm_ok && fm_ok && bp_ok;
  assign on_proc = (xpsr_i[8:0] <= 9'd1) && control_i[1];
  assign exc_n   = $unsigned(req_irq_i) + EXC_OFS;
  assign unused_bits = ^{exc_ret_val_i[31:3], exc_ret_val_i[1:0], base_pri_i[3:0]};

  assign busy_o = (st != S_IDLE);

  always_comb begin
    reg_raddr_o = 4'd0;
    case (st)
      S_E_SP:  reg_raddr_o = proc_q ? RG_PSP : RG_MSP;
      S_E_RD:  reg_raddr_o = 4'(3'd7 - cnt);
      S_R_SP:  reg_raddr_o = ret_q ? RG_PSP : RG_MSP;
      default: reg_raddr_o = 4'd0;
    endcase
  end

  always_comb begin
    reg_we_o    = 1'b1;
    reg_waddr_o = 4'd0;
    reg_wdata_o = 32'd0;
    case (st)
      S_E_SPW: begin
        reg_waddr_o = proc_q ? RG_PSP : RG_MSP;
        reg_wdata_o = sp;
      end
      S_E_XPSR: begin
        reg_waddr_o = RG_XPSR;
        reg_wdata_o = {xpsr_i[31:EXCW], exc_q};
      end
      S_E_PC: begin
        reg_waddr_o = RG_PC;
        reg_wdata_o = wbuf;
      end
      S_E_LR: begin
        reg_waddr_o = RG_LR;
        reg_wdata_o = proc_q ? RET_PROC : RET_MAIN;
      end
      S_R_XPSR: begin
        reg_waddr_o = RG_XPSR;
        reg_wdata_o = {xpsr_i[31:EXCW], {EXCW{1'b0}}};
      end
      S_R_CTRL: begin
        reg_waddr_o = RG_CTRL;
        reg_wdata_o = {control_i[31:2], ret_q, control_i[0]};
      end
      S_R_WR: begin
        reg_waddr_o = {1'b0, cnt};
        reg_wdata_o = (cnt == 3'd7) ?
          {wbuf[31:27], xpsr_i[26:20], wbuf[19:16], xpsr_i[15:0]} : wbuf;
      end
      S_R_SPW: begin
        reg_waddr_o = ret_q ? RG_PSP : RG_MSP;
        reg_wdata_o = sp;
      end
      default: reg_we_o = 1'b0;
    endcase
  end

  assign mem_req_o   = (st == S_E_WR) || (st == S_E_VEC) || (st == S_R_RD);
  assign mem_we_o    = (st == S_E_WR);
  assign mem_wdata_o = (st == S_E_WR) ? wbuf : 32'd0;
  assign mem_addr_o  = (st == S_E_VEC) ? {{(30-EXCW){1'b0}}, exc_q, 2'b00} :
                       mem_req_o ? sp : 32'd0;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) svc_pend_o <= 1'b0;
    else         svc_pend_o <= svc_trap_i;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      st     <= S_IDLE;
      cnt    <= 3'd0;
      sp     <= 32'd0;
      wbuf   <= 32'd0;
      exc_q  <= '0;
      proc_q <= 1'b0;
      ret_q  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (exc_ret_i) begin
            ret_q <= exc_ret_val_i[2];
            st    <= S_R_XPSR;
          end else if (take) begin
            exc_q  <= exc_n;
            proc_q <= on_proc;
            st     <= S_E_SP;
          end
        end
        S_E_SP: begin
          sp  <= reg_rdata_i;
          cnt <= 3'd0;
          st  <= S_E_RD;
        end
        S_E_RD: begin
          wbuf <= reg_rdata_i;
          sp   <= sp - 32'd4;
          st   <= S_E_WR;
        end
        S_E_WR: if (mem_ack_i) begin
          if (cnt == 3'd7) st <= S_E_SPW;
          else begin
            cnt <= cnt + 3'd1;
            st  <= S_E_RD;
          end
        end
        S_E_SPW: st <= S_E_VEC;
        S_E_VEC: if (mem_ack_i) begin
          wbuf <= mem_rdata_i;
          st   <= S_E_XPSR;
        end
        S_E_XPSR: st <= S_E_PC;
        S_E_PC:   st <= S_E_LR;
        S_E_LR:   st <= S_IDLE;
        S_R_XPSR: st <= S_R_CTRL;
        S_R_CTRL: st <= S_R_SP;
        S_R_SP: begin
          sp  <= reg_rdata_i;
          cnt <= 3'd0;
          st  <= S_R_RD;
        end
        S_R_RD: if (mem_ack_i) begin
          wbuf <= mem_rdata_i;
          sp   <= sp + 32'd4;
          st   <= S_R_WR;
        end
        S_R_WR: begin
          if (cnt == 3'd7) st <= S_R_SPW;
          else begin
            cnt <= cnt + 3'd1;
            st  <= S_R_RD;
          end
        end
        S_R_SPW: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/exc_seq_chk.sv
module exc_seq_chk #(
  parameter int EXCW = 9
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   req_valid_i,
  input logic signed [EXCW-1:0] req_irq_i,
  input logic [7:0]             req_prio_i,
  input logic                   exc_ret_i,
  input logic                   svc_trap_i,
  input logic                   pri_mask_i,
  input logic                   flt_mask_i,
  input logic [7:0]             base_pri_i,
  input logic                   reg_we_o,
  input logic                   mem_req_o,
  input logic                   mem_we_o,
  input logic [31:0]            mem_addr_o,
  input logic [31:0]            mem_wdata_o,
  input logic                   mem_ack_i,
  input logic                   busy_o,
  input logic                   svc_pend_o
);

  p_pri_mask_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && req_valid_i && !exc_ret_i && pri_mask_i && (req_irq_i > -13)) |=> !busy_o);

  p_flt_mask_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && req_valid_i && !exc_ret_i && flt_mask_i && (req_irq_i != -14)) |=> !busy_o);

  p_base_pri_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && req_valid_i && !exc_ret_i && (base_pri_i[7:4] != 4'd0) &&
     ({base_pri_i[7:4], 4'h0} <= req_prio_i)) |=> !busy_o);

  p_idle_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mem_req_o && !reg_we_o));

  p_word_aligned_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[1:0] == 2'b00));

  p_svc_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc_trap_i |=> svc_pend_o);

  p_req_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=>
      (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)));

endmodule

bind exc_seq exc_seq_chk #(.EXCW(EXCW)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_irq_i(req_irq_i),
  .req_prio_i(req_prio_i), .exc_ret_i(exc_ret_i), .svc_trap_i(svc_trap_i),
  .pri_mask_i(pri_mask_i), .flt_mask_i(flt_mask_i), .base_pri_i(base_pri_i),
  .reg_we_o(reg_we_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
  .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i),
  .busy_o(busy_o), .svc_pend_o(svc_pend_o)
);

// File: tb/exc_seq_tb.sv
module exc_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic              req_valid = 1'b0;
  logic signed [8:0] req_irq = '0;
  logic [7:0]        req_prio = '0;
  logic              exc_ret = 1'b0;
  logic [31:0]       exc_ret_val = '0;
  logic              svc_trap = 1'b0;
  logic              pri_mask = 1'b0, flt_mask = 1'b0;
  logic [7:0]        base_pri = '0;
  logic [3:0]        reg_raddr, reg_waddr;
  logic [31:0]       reg_rdata, reg_wdata;
  logic              reg_we;
  logic              mem_req, mem_we, mem_ack;
  logic [31:0]       mem_addr, mem_wdata, mem_rdata;
  logic              busy, svc_pend;

  logic [31:0] rf [0:10];
  logic [31:0] mem [0:1023];

  int checks = 0;
  int errors = 0;
  int acc_cnt = 0;

  logic [31:0] fr [0:7];
  logic [31:0] fr_sp;
  bit          fr_proc;

  assign reg_rdata = (reg_raddr <= 4'd10) ? rf[reg_raddr] : 32'd0;
  assign mem_rdata = mem[mem_addr[11:2]];

  exc_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_irq_i(req_irq),
    .req_prio_i(req_prio), .exc_ret_i(exc_ret), .exc_ret_val_i(exc_ret_val),
    .svc_trap_i(svc_trap), .pri_mask_i(pri_mask), .flt_mask_i(flt_mask),
    .base_pri_i(base_pri), .xpsr_i(rf[7]), .control_i(rf[10]),
    .reg_raddr_o(reg_raddr), .reg_rdata_i(reg_rdata), .reg_we_o(reg_we),
    .reg_waddr_o(reg_waddr), .reg_wdata_o(reg_wdata), .mem_req_o(mem_req),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack), .busy_o(busy), .svc_pend_o(svc_pend)
  );

  always @(posedge clk) begin
    if (reg_we && reg_waddr <= 4'd10) rf[reg_waddr] <= reg_wdata;
    if (!rst_n) mem_ack <= 1'b0;
    else        mem_ack <= mem_req && !mem_ack && (($urandom % 3) != 0);
    if (mem_req && mem_ack) begin
      acc_cnt <= acc_cnt + 1;
      if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic bit f_accept(int irq, logic [7:0] prio, bit pm, bit fm, logic [7:0] bp);
    if (pm && irq > -13) return 1'b0;
    if (fm && irq != -14) return 1'b0;
    if (bp[7:4] != 4'd0 && {bp[7:4], 4'h0} <= prio) return 1'b0;
    return 1'b1;
  endfunction

  function automatic string f_reject_tag(int irq, bit pm, bit fm);
    if (pm && irq > -13) return "R1 primask reject";
    if (fm && irq != -14) return "R2 faultmask reject";
    return "R3 basepri reject";
  endfunction

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic run_entry(input int irq, input logic [7:0] prio, input bit pm, input bit fm,
                           input logic [7:0] bp, input logic [8:0] field, input bit spsel,
                           input bit poke, output bit taken);
    logic [31:0] tmp;
    logic [31:0] sp0;
    logic [8:0]  exc;
    int          acc0;
    @(negedge clk);
    for (int i = 0; i < 7; i++) rf[i] = $urandom;
    tmp = $urandom;
    rf[7]  = {tmp[31:9], field};
    rf[8]  = 32'h0000_0F00;
    rf[9]  = 32'h0000_0B00;
    rf[10] = {30'd0, spsel, 1'b0};
    for (int k = 0; k < 8; k++) fr[k] = rf[k];
    fr_proc = (field <= 9'd1) && spsel;
    sp0 = fr_proc ? 32'h0B00 : 32'h0F00;
    exc = 9'(irq + 16);
    taken = f_accept(irq, prio, pm, fm, bp);
    pri_mask = pm; flt_mask = fm; base_pri = bp;
    req_irq = 9'(irq); req_prio = prio; req_valid = 1'b1;
    acc0 = acc_cnt;
    @(negedge clk);
    req_valid = 1'b0;
    if (!taken) begin
      chk(busy == 1'b0, f_reject_tag(irq, pm, fm), {31'd0, busy}, 32'd0);
      repeat (4) @(negedge clk);
      chk(!busy && acc_cnt == acc0 && rf[6] == fr[6] && rf[5] == fr[5],
          f_reject_tag(irq, pm, fm), rf[6], fr[6]);
      return;
    end
    chk(busy == 1'b1, "R4 busy after accept", {31'd0, busy}, 32'd1);
    if (poke) begin
      pri_mask = 1'b0; flt_mask = 1'b0; base_pri = 8'd0;
      req_irq = -9'sd14; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
    end
    wait_idle();
    chk(!busy, "R4 sequence ends", {31'd0, busy}, 32'd0);
    for (int k = 0; k < 8; k++) begin
      tmp = sp0 - 32'(4 * (k + 1));
      chk(mem[tmp[11:2]] == fr[7 - k], "R5 frame word", mem[tmp[11:2]], fr[7 - k]);
    end
    chk(rf[fr_proc ? 9 : 8] == sp0 - 32'd32, "R5 stack pointer", rf[fr_proc ? 9 : 8], sp0 - 32'd32);
    chk(rf[6] == mem[exc], "R6 pc from vector", rf[6], mem[exc]);
    chk(rf[7] == {fr[7][31:9], exc}, "R6 xpsr exception number", rf[7], {fr[7][31:9], exc});
    tmp = fr_proc ? 32'hFFFF_FFFD : 32'hFFFF_FFF9;
    chk(rf[5] == tmp, "R7 link value", rf[5], tmp);
    repeat (3) @(negedge clk);
    chk(!busy && acc_cnt - acc0 == 9, "R12 entry access count (R4 no restart)",
        32'(acc_cnt - acc0), 32'd9);
    fr_sp = sp0;
  endtask

  task automatic run_return();
    logic [31:0] retv, rnd, old, expx, tmp;
    int acc0;
    @(negedge clk);
    retv = rf[5];
    rnd = $urandom;
    tmp = fr_sp - 32'd4;
    mem[tmp[11:2]] = rnd;
    for (int i = 0; i < 7; i++) rf[i] = $urandom;
    old = rf[7];
    exc_ret = 1'b1; exc_ret_val = retv;
    acc0 = acc_cnt;
    @(negedge clk);
    exc_ret = 1'b0;
    chk(busy == 1'b1, "R8 return starts", {31'd0, busy}, 32'd1);
    wait_idle();
    chk(rf[10][1] == retv[2], "R8 stack select bit", rf[10], {29'd0, retv[2], 2'b0});
    chk(rf[7][8:0] == 9'd0, "R8 exception number cleared", rf[7], 32'd0);
    for (int k = 0; k < 7; k++)
      chk(rf[k] == fr[k], "R9 restored register", rf[k], fr[k]);
    chk(rf[retv[2] ? 9 : 8] == fr_sp, "R9 stack pointer back", rf[retv[2] ? 9 : 8], fr_sp);
    expx = {rnd[31:27], old[26:20], rnd[19:16], old[15:9], 9'd0};
    chk(rf[7] == expx, "R10 flags-only restore", rf[7], expx);
    chk(acc_cnt - acc0 == 8, "R12 return access count", 32'(acc_cnt - acc0), 32'd8);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit t;
    void'($urandom(32'd2024));
    for (int i = 0; i < 1024; i++) mem[i] = 32'd0;
    for (int i = 0; i < 64; i++) mem[i] = 32'h0800_0001 + 32'(i * 64);
    for (int i = 0; i < 11; i++) rf[i] = 32'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !svc_pend && !mem_req, "R4 reset idle", {31'd0, busy}, 32'd0);

    @(negedge clk); svc_trap = 1'b1;
    @(negedge clk); svc_trap = 1'b0;
    chk(svc_pend && !busy, "R11 svc pending pulse", {31'd0, svc_pend}, 32'd1);
    @(negedge clk);
    chk(!svc_pend, "R11 pulse one cycle", {31'd0, svc_pend}, 32'd0);

    run_entry(-13, 8'h20, 1'b1, 1'b0, 8'h00, 9'd0, 1'b0, 1'b0, t);
    chk(t, "R1 hard fault exempt", {31'd0, t}, 32'd1);
    run_return();
    run_entry(-5, 8'h20, 1'b1, 1'b0, 8'h00, 9'd0, 1'b0, 1'b0, t);
    run_entry(-14, 8'h00, 1'b0, 1'b1, 8'h00, 9'd0, 1'b1, 1'b1, t);
    run_return();
    run_entry(-13, 8'h00, 1'b0, 1'b1, 8'h00, 9'd0, 1'b0, 1'b0, t);
    run_entry(3, 8'h40, 1'b0, 1'b0, 8'h40, 9'd0, 1'b0, 1'b0, t);
    run_entry(3, 8'h30, 1'b0, 1'b0, 8'h40, 9'd1, 1'b1, 1'b0, t);
    run_return();
    run_entry(7, 8'hFF, 1'b0, 1'b0, 8'h0F, 9'd3, 1'b1, 1'b0, t);
    run_return();

    for (int it = 0; it < 80; it++) begin
      int irq, r;
      logic [7:0] prio, bp;
      logic [8:0] field;
      bit pm, fm, sps, pk;
      r = int'($urandom % 6);
      irq = (r == 0) ? -14 : (r == 1) ? -13 : (r == 2) ? -5 : (r == 3) ? -1 : int'($urandom % 32);
      prio = 8'($urandom);
      pm = (($urandom % 4) == 0);
      fm = (($urandom % 5) == 0);
      bp = (($urandom % 3) == 0) ? 8'($urandom) : 8'd0;
      field = (($urandom % 2) == 0) ? 9'd0 : ((($urandom % 2) == 0) ? 9'd1 : 9'd3);
      sps = 1'($urandom);
      pk = (($urandom % 4) == 0);
      run_entry(irq, prio, pm, fm, bp, field, sps, pk, t);
      if (t) run_return();
    end

    repeat (2) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule